// File: doc/BRIEF.md
# Ancillary Packet Presence Flagger

This block watches a stream of 10-bit colour-difference video words, one word per accepted pixel-clock strobe. It raises a single flag for every word of each embedded ancillary data packet. A packet is recognised by its three-word preamble (0x000, 0x3FF, 0x3FF). That preamble is followed by a data ID word, a secondary ID (or block number) word and a data count word. The flag length is taken only from the data count. A corrupted count therefore gives a flag of the wrong length, and a packet with a damaged preamble gets no flag at all.

The block holds the words back in a short delay line. This lets it read the count word before the first preamble word leaves, so the flag rises on that first word of the delayed output. The flag stays aligned with the delayed word for the rest of the packet. The block has no notion of picture region, so packets are flagged the same way in horizontal blanking and in the active picture. The block does not decode the payload, check the checksum or store any data.

Top module: `anc_flagger`

## Requirements
- R1: While reset is asserted, and until the first accepted word has been passed through, `out_vld`, `out_flag` and `out_word` are all zero.
- R2: The word accepted on strobe k is driven on `out_word` after the clock edge of strobe k+5. Every accepted word appears exactly once, in order. The five words sent out before the first accepted one are 0x000.
- R3: `out_vld` equals `in_vld` delayed by one clock.
- R4: A window of accepted words 0x000, 0x3FF, 0x3FF, ID, SID, COUNT starts a packet. `out_flag` goes high on the same output word as the 0x000.
- R5: `out_flag` stays high for exactly 7 + COUNT[7:0] output words. Bits 9:8 of the count word have no effect on the length.
- R6: If any of the three preamble words differs from 0x000, 0x3FF, 0x3FF, no flag is raised for that packet.
- R7: A packet with COUNT[7:0] = 0 is flagged for exactly 7 words.
- R8: A preamble that starts while a packet is still flagged is ignored. The flag drops when the current packet's length runs out.
- R9: A packet whose 0x000 comes on the output word directly after the last flagged word of the previous packet is flagged too. The flag then stays high without a gap.
- R10: On a clock with `in_vld` low, nothing moves: `out_word`, `out_flag` and the remaining length all hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_vld | input | 1 | Word strobe for `in_word` |
| in_word | input | 10 | Incoming colour-difference word |
| out_vld | output | 1 | Strobe for the delayed word |
| out_word | output | 10 | Input word delayed by five accepted words |
| out_flag | output | 1 | High on every word of a detected ancillary packet |

## Verification
The bound checker checks these on every clock:
- the one-clock strobe delay;
- the hold on idle clocks;
- that the flag only rises on a 0x000 output word;
- that a detected preamble with the counter idle loads a length of the count plus six;
- that a running count always keeps the flag high and steps down by one.

Only the bench scenarios can show the rest, because each depends on whole packets and on what the stream held earlier:
- the full flag length against the count word;
- that damaged preambles are rejected;
- that nested preambles are ignored;
- that back-to-back packets join up;
- that gapped input does not change the result.

// File: rtl/anc_pkg.sv
package anc_pkg;
  localparam int unsigned WORD_W   = 10;
  localparam int unsigned DC_W     = 8;
  localparam int unsigned PRE_LEN  = 3;
  localparam int unsigned HDR_LEN  = PRE_LEN + 3;
  localparam int unsigned OVERHEAD = HDR_LEN + 1;
  localparam int unsigned CNT_W    = $clog2((1 << DC_W) + OVERHEAD);

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  localparam word_t PRE_LO = '0;
  localparam word_t PRE_HI = '1;
endpackage

// File: rtl/anc_delay_line.sv
module anc_delay_line
  import anc_pkg::*;
#(
  parameter int unsigned DEPTH = HDR_LEN - 1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv,
  input  word_t din,
  output word_t tap [DEPTH]
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_stg
    word_t d;
    if (i == 0) begin : g_head
      assign d = din;
    end else begin : g_body
      assign d = tap[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   tap[i] <= '0;
      else if (adv) tap[i] <= d;
    end
  end
endmodule

// File: rtl/anc_hdr_match.sv
module anc_hdr_match
  import anc_pkg::*;
(
  input  word_t            win [HDR_LEN],
  output logic             hit,
  output logic [DC_W-1:0]  dc
);
  logic [PRE_LEN-1:0] m;

  for (genvar p = 0; p < PRE_LEN; p++) begin : g_pre
    localparam word_t EXP = (p == 0) ? PRE_LO : PRE_HI;
    assign m[p] = (win[HDR_LEN-1-p] == EXP);
  end

  assign hit = &m;
  assign dc  = win[0][DC_W-1:0];
endmodule

// File: rtl/anc_span_ctr.sv
module anc_span_ctr
  import anc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic            hit,
  input  logic [DC_W-1:0] dc,
  output logic            flag_q,
  output cnt_t            left_q
);
  logic flag_d;
  cnt_t left_d;

  always_comb begin
    flag_d = flag_q;
    left_d = left_q;
    if (adv) begin
      if (left_q != '0) begin
        flag_d = 1'b1;
        left_d = left_q - cnt_t'(1);
      end else if (hit) begin
        flag_d = 1'b1;
        left_d = cnt_t'(dc) + cnt_t'(OVERHEAD - 1);
      end else begin
        flag_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      left_q <= '0;
    end else begin
      flag_q <= flag_d;
      left_q <= left_d;
    end
  end
endmodule

// File: rtl/anc_flagger.sv
module anc_flagger
  import anc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_vld,
  output logic [WORD_W-1:0] out_word,
  output logic              out_flag
);
  localparam int unsigned DEPTH = HDR_LEN - 1;

  // reset: asserted at once, released after two clock edges
  logic [1:0] rs_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  word_t tap [DEPTH];
  word_t win [HDR_LEN];
  logic            hdr_hit;
  logic [DC_W-1:0] hdr_dc;
  cnt_t            span_left;

  anc_delay_line #(.DEPTH(DEPTH)) u_dly (
    .clk(clk), .rst_n(rst_s), .adv(in_vld), .din(in_word), .tap(tap)
  );

  assign win[0] = in_word;
  for (genvar i = 1; i < HDR_LEN; i++) begin : g_win
    assign win[i] = tap[i-1];
  end

  anc_hdr_match u_match (.win(win), .hit(hdr_hit), .dc(hdr_dc));

  anc_span_ctr u_span (
    .clk(clk), .rst_n(rst_s), .adv(in_vld), .hit(hdr_hit), .dc(hdr_dc),
    .flag_q(out_flag), .left_q(span_left)
  );

  logic  vld_d;
  word_t word_d;
  always_comb begin
    vld_d  = in_vld;
    word_d = in_vld ? tap[DEPTH-1] : out_word;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      out_vld  <= 1'b0;
      out_word <= '0;
    end else begin
      out_vld  <= vld_d;
      out_word <= word_d;
    end
  end
endmodule

// File: rtl/anc_flagger_chk.sv
module anc_flagger_chk
  import anc_pkg::*;
(
  input logic              clk,
  input logic              rst_s,
  input logic              in_vld,
  input logic [WORD_W-1:0] in_word,
  input logic              out_vld,
  input logic [WORD_W-1:0] out_word,
  input logic              out_flag,
  input logic              hdr_hit,
  input cnt_t              span_left
);
  p_vld_delay_r3: assert property (@(posedge clk) disable iff (!rst_s)
    $past(rst_s) |-> out_vld == $past(in_vld));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_s)
    $past(rst_s) && !$past(in_vld) |-> $stable(out_word) && $stable(out_flag) && $stable(span_left));

  p_rise_on_pre_r4: assert property (@(posedge clk) disable iff (!rst_s)
    $past(rst_s) && $rose(out_flag) |-> out_word == PRE_LO);

  p_len_load_r5: assert property (@(posedge clk) disable iff (!rst_s)
    in_vld && span_left == '0 && hdr_hit |=>
      out_flag && span_left == cnt_t'($past(in_word[DC_W-1:0])) + cnt_t'(OVERHEAD - 1));

  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_s)
    in_vld && span_left != '0 |=> out_flag && span_left == $past(span_left) - cnt_t'(1));
endmodule

bind anc_flagger anc_flagger_chk chk_i (
  .clk(clk), .rst_s(rst_s), .in_vld(in_vld), .in_word(in_word),
  .out_vld(out_vld), .out_word(out_word), .out_flag(out_flag),
  .hdr_hit(hdr_hit), .span_left(span_left)
);

// File: tb/anc_flagger_tb_top.sv
`timescale 1ns/1ps
module anc_flagger_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_vld;
  logic [9:0] in_word;
  logic       out_vld;
  logic [9:0] out_word;
  logic       out_flag;

  always #2.5 clk = ~clk;

  anc_flagger dut_i (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_word(in_word),
    .out_vld(out_vld), .out_word(out_word), .out_flag(out_flag)
  );

  typedef struct { logic [9:0] w; logic f; string tag; } exp_t;
  exp_t       sb[$];
  logic [9:0] strm[$];
  int         end_i;
  string      cur_tag;
  int         n_tot, n_fail;
  bit         mon_on, have_last, done;
  logic [9:0] last_w;
  logic       last_f;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_tot++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // reference model: stream = five reset zeros, then accepted words
  task automatic model(input logic [9:0] w);
    exp_t e;
    int k;
    logic f;
    strm.push_back(w);
    k = strm.size() - 6;
    f = 1'b0;
    if (k < end_i) f = 1'b1;
    else if (strm[k] == 10'h000 && strm[k+1] == 10'h3FF && strm[k+2] == 10'h3FF) begin
      f = 1'b1;
      end_i = k + 7 + int'(strm[k+5][7:0]);
    end
    e.w = strm[k]; e.f = f; e.tag = cur_tag;
    sb.push_back(e);
  endtask

  task automatic put(input logic [9:0] w, input int gap);
    @(negedge clk);
    in_vld = 1'b1; in_word = w;
    model(w);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      in_vld = 1'b0;
    end
  endtask

  task automatic fill(input int n);
    for (int i = 0; i < n; i++) put(10'h040, 0);
  endtask

  task automatic pkt(input logic [9:0] p0, input logic [9:0] p1, input logic [9:0] p2,
                     input logic [9:0] dc, input int npay, input int gap);
    put(p0, gap); put(p1, gap); put(p2, gap);
    put(10'h141, gap); put(10'h105, gap); put(dc, gap);
    for (int i = 0; i < npay; i++) put(10'h200 + 10'(i), gap);
    put(10'h155, gap);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_on) begin
      if (out_vld) begin
        if (sb.size() == 0) chk(1'b0, "R2", "unexpected output word", int'(out_word), 0);
        else begin
          exp_t e;
          e = sb.pop_front();
          chk(out_word == e.w, "R2", "out_word", int'(out_word), int'(e.w));
          chk(out_flag == e.f, e.tag, "out_flag", int'(out_flag), int'(e.f));
        end
      end else if (have_last) begin
        chk(out_word == last_w && out_flag == last_f, "R10", "hold on idle clock",
            int'({out_flag, out_word}), int'({last_f, last_w}));
      end
      last_w = out_word; last_f = out_flag; have_last = 1'b1;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      n_tot++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
      $finish;
    end
  end

  initial begin
    n_tot = 0; n_fail = 0; end_i = 0; mon_on = 0; have_last = 0; done = 0;
    for (int i = 0; i < 5; i++) strm.push_back(10'h000);
    rst_n = 1'b0; in_vld = 1'b0; in_word = 10'h000;
    repeat (4) @(negedge clk);
    chk(out_vld == 1'b0, "R1", "out_vld in reset", int'(out_vld), 0);
    chk(out_flag == 1'b0, "R1", "out_flag in reset", int'(out_flag), 0);
    chk(out_word == 10'h000, "R1", "out_word in reset", int'(out_word), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_vld == 1'b0 && out_flag == 1'b0, "R1", "outputs after release",
        int'({out_vld, out_flag}), 0);
    mon_on = 1'b1;

    cur_tag = "R2"; fill(8);
    cur_tag = "R4"; pkt(10'h000, 10'h3FF, 10'h3FF, 10'h003, 3, 0); fill(4);
    cur_tag = "R5"; pkt(10'h000, 10'h3FF, 10'h3FF, 10'h205, 5, 0); fill(3);
    cur_tag = "R6";
    pkt(10'h000, 10'h3FE, 10'h3FF, 10'h002, 2, 0); fill(2);
    pkt(10'h001, 10'h3FF, 10'h3FF, 10'h002, 2, 0); fill(2);
    pkt(10'h000, 10'h3FF, 10'h3BF, 10'h002, 2, 0); fill(3);
    cur_tag = "R8";
    put(10'h000, 0); put(10'h3FF, 0); put(10'h3FF, 0);
    put(10'h150, 0); put(10'h101, 0); put(10'h008, 0);
    put(10'h000, 0); put(10'h3FF, 0); put(10'h3FF, 0); put(10'h160, 0);
    put(10'h102, 0); put(10'h020, 0); put(10'h111, 0); put(10'h122, 0);
    put(10'h133, 0); fill(6);
    cur_tag = "R7"; pkt(10'h000, 10'h3FF, 10'h3FF, 10'h000, 0, 0);
    cur_tag = "R9"; pkt(10'h000, 10'h3FF, 10'h3FF, 10'h001, 1, 0); fill(4);
    cur_tag = "R10"; pkt(10'h000, 10'h3FF, 10'h3FF, 10'h002, 2, 2); fill(6);
    @(negedge clk); in_vld = 1'b0;
    repeat (10) @(negedge clk);
    chk(sb.size() == 0, "R2", "all expected words seen", sb.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
    $finish;
  end
endmodule